// File: doc/BRIEF.md
# FSK Carrier Detect Qualifier

This block sits between an FSK band-pass energy detector and the serial data paths of a caller-identity receiver. It takes a raw per-sample activity flag and turns it into a qualified, active-low carrier-detect output. Acquisition requires activity in a run of consecutive 1 ms ticks. Once carrier is declared, a hold timer keeps it declared across short drop-outs. It is released only after a fixed number of consecutive ticks with no activity.

The same qualification gates the two downstream paths. In stream mode (`mode_i` = 0) the raw demodulated bit passes to `stream_o` only while carrier is held; otherwise that output sits at 1. In byte mode (`mode_i` = 1) `rx_gate_o` lets the byte receiver update its buffer, and only while carrier is held. Disabling FSK clears all qualification state.

The controller has three named states:
- OFF: FSK disabled.
- SEEK: acquiring.
- LOCK: carrier held.

Its transitions are:
- OFF→SEEK on enable.
- SEEK→LOCK on the ACQ_TICKS-th consecutive active tick.
- SEEK→SEEK with the count cleared on an empty tick.
- LOCK→SEEK on the HOLD_TICKS-th consecutive empty tick.
- Any state→OFF when enable drops.

Top module: `cdq_carrier_qual`

## Requirements
- R1: After reset `cd_n_o` = 1, `stream_o` = 1 and `rx_gate_o` = 0.
- R2: In the clock after `fsk_en_i` is sampled low, the block is in OFF with `cd_n_o` = 1, and both tick counters and the activity latch are cleared. After re-enable, a full ACQ_TICKS run of active ticks is needed again.
- R3: In SEEK, `cd_n_o` goes to 0 in the clock after the ACQ_TICKS-th consecutive active tick (default 20). Activity without `tick_i` never advances acquisition.
- R4: In SEEK, a tick with no activity resets the acquisition run to zero.
- R5: A tick counts as active if `act_i` was high in any cycle since the previous tick, the tick cycle itself included.
- R6: In LOCK, an active tick restarts the hold timer. `cd_n_o` returns to 1 in the clock after the HOLD_TICKS-th consecutive empty tick (default 10), and not before.
- R7: After a release from LOCK, reacquisition needs a fresh ACQ_TICKS run.
- R8: `stream_o` equals `raw_bit_i` when in LOCK with `mode_i` = 0, and is 1 otherwise.
- R9: `rx_gate_o` is 1 exactly when in LOCK with `mode_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsk_en_i | input | 1 | FSK demodulation enabled |
| act_i | input | 1 | Raw band-pass activity flag |
| tick_i | input | 1 | 1 ms tick, one cycle wide |
| mode_i | input | 1 | 0 = bit stream, 1 = byte buffer |
| raw_bit_i | input | 1 | Raw demodulator bit |
| cd_n_o | output | 1 | Carrier detect, active low |
| stream_o | output | 1 | Gated stream-mode data |
| rx_gate_o | output | 1 | Byte receiver update enable |

## Verification
The bench targets run lengths of one less than each limit: 19 active ticks, and 9 empty ticks after lock. An off-by-one counter would then declare or drop carrier one tick early or late. A single empty tick placed late in an acquisition run catches a design that only pauses the count instead of restarting it. Activity that falls only between ticks, or only on the tick cycle, catches a missing or badly cleared activity latch. A disable in the middle of a lock, followed by 19 active ticks, catches counters that survive the disable. The output muxes are checked in both modes under random stimulus.

// File: rtl/cdq_pkg.sv
package cdq_pkg;
    typedef enum logic [1:0] {
        CDQ_OFF  = 2'd0,
        CDQ_SEEK = 2'd1,
        CDQ_LOCK = 2'd2
    } cdq_state_e;
endpackage

// File: rtl/cdq_act_latch.sv
module cdq_act_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic seen_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     seen_o <= 1'b0;
        else if (clr_i) seen_o <= 1'b0;
        else if (set_i) seen_o <= 1'b1;
    end

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> seen_o);
endmodule

// File: rtl/cdq_tick_cnt.sv
module cdq_tick_cnt #(
    parameter int MAX = 20,
    localparam int W  = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_o <= '0;
        else if (clr_i) cnt_o <= '0;
        else if (inc_i) cnt_o <= cnt_o + W'(1);
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= W'(MAX));
endmodule

// File: rtl/cdq_carrier_qual.sv
module cdq_carrier_qual
    import cdq_pkg::*;
#(
    parameter int ACQ_TICKS  = 20,
    parameter int HOLD_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsk_en_i,
    input  logic act_i,
    input  logic tick_i,
    input  logic mode_i,
    input  logic raw_bit_i,
    output logic cd_n_o,
    output logic stream_o,
    output logic rx_gate_o
);
    localparam int AW = $clog2(ACQ_TICKS + 1);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    cdq_state_e state_q, state_d;
    logic          seen_q, hit;
    logic [AW-1:0] acq_cnt;
    logic [HW-1:0] hold_cnt;
    logic          acq_done, hold_done;

    cdq_act_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (act_i),
        .clr_i  (tick_i || !fsk_en_i),
        .seen_o (seen_q)
    );

    assign hit = seen_q || act_i;

    cdq_tick_cnt #(.MAX(ACQ_TICKS)) u_acq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (!fsk_en_i || state_q != CDQ_SEEK || (tick_i && !hit)),
        .inc_i (tick_i && hit),
        .cnt_o (acq_cnt)
    );

    cdq_tick_cnt #(.MAX(HOLD_TICKS)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (!fsk_en_i || state_q != CDQ_LOCK || (tick_i && hit)),
        .inc_i (tick_i && !hit),
        .cnt_o (hold_cnt)
    );

    assign acq_done  = tick_i && hit  && (acq_cnt  == AW'(ACQ_TICKS - 1));
    assign hold_done = tick_i && !hit && (hold_cnt == HW'(HOLD_TICKS - 1));

    always_comb begin
        state_d = state_q;
        if (!fsk_en_i) begin
            state_d = CDQ_OFF;
        end else begin
            unique case (state_q)
                CDQ_OFF:  state_d = CDQ_SEEK;
                CDQ_SEEK: if (acq_done)  state_d = CDQ_LOCK;
                CDQ_LOCK: if (hold_done) state_d = CDQ_SEEK;
                default:  state_d = CDQ_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CDQ_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        cd_n_o    = 1'b1;
        stream_o  = 1'b1;
        rx_gate_o = 1'b0;
        unique case (state_q)
            CDQ_LOCK: begin
                cd_n_o    = 1'b0;
                stream_o  = mode_i ? 1'b1 : raw_bit_i;
                rx_gate_o = mode_i;
            end
            default: ;
        endcase
    end

    // R3
    acq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cd_n_o) |-> $past(tick_i && hit && fsk_en_i));
    // R6
    hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cd_n_o) |-> ($past(!fsk_en_i) || $past(tick_i && !hit)));
    // R2
    off_cd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fsk_en_i |=> cd_n_o);
    // R8
    stream_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_n_o || mode_i) |-> stream_o);
    // R9
    gate_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_gate_o |-> (mode_i && !cd_n_o));
endmodule

// File: tb/sim_cdq_carrier_qual.sv
module sim_cdq_carrier_qual;
    localparam int ACQ  = 20;
    localparam int HOLD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 1'b0, act = 1'b0, tk = 1'b0, md = 1'b0, bt = 1'b0;
    logic cd_n, strm, gate;
    int   n_run = 0, n_fail = 0;

    int m_state = 0, m_acq = 0, m_hold = 0;
    bit m_seen = 0;

    always #4 clk = ~clk;

    cdq_carrier_qual #(.ACQ_TICKS(ACQ), .HOLD_TICKS(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .fsk_en_i(en), .act_i(act), .tick_i(tk),
        .mode_i(md), .raw_bit_i(bt), .cd_n_o(cd_n), .stream_o(strm), .rx_gate_o(gate)
    );

    task automatic chk(input string tag, input logic act_v, input logic exp_v);
        n_run++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic model_step(input bit e, input bit a, input bit t);
        bit h;
        h = m_seen || a;
        if (!e) begin
            m_state = 0; m_acq = 0; m_hold = 0;
        end else if (m_state == 0) begin
            m_state = 1; m_acq = 0;
        end else if (m_state == 1 && t) begin
            if (!h) m_acq = 0;
            else if (m_acq == ACQ - 1) begin m_state = 2; m_hold = 0; m_acq = 0; end
            else m_acq++;
        end else if (m_state == 2 && t) begin
            if (h) m_hold = 0;
            else if (m_hold == HOLD - 1) begin m_state = 1; m_acq = 0; m_hold = 0; end
            else m_hold++;
        end
        if (t || !e) m_seen = 0;
        else if (a) m_seen = 1;
    endtask

    task automatic cyc(input bit e, input bit a, input bit t, input bit m, input string tag);
        en = e; act = a; tk = t; md = m; bt = 1'($urandom);
        model_step(e, a, t);
        @(posedge clk);
        @(negedge clk);
        chk(tag, cd_n, logic'(m_state != 2));
        chk("R8", strm, (m_state == 2 && !md) ? bt : 1'b1);
        chk("R9", gate, logic'(m_state == 2 && md));
    endtask

    task automatic ticks(input int n, input bit a, input bit m, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1, 0, 0, m, tag);
            cyc(1, a, 0, m, tag);
            cyc(1, 0, 1, m, tag);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", cd_n, 1'b1); chk("R1", strm, 1'b1); chk("R1", gate, 1'b0);
        rst_n = 1'b1;
        cyc(1, 0, 0, 0, "R2");
        // R3 activity without ticks does nothing
        for (int i = 0; i < 60; i++) cyc(1, 1, 0, 0, "R3");
        chk("R3", cd_n, 1'b1);
        // R3 boundary 19 then 20
        ticks(ACQ - 1, 1, 0, "R3"); chk("R3", cd_n, 1'b1);
        ticks(1, 1, 0, "R3");       chk("R3", cd_n, 1'b0);
        // R6 hold timer
        ticks(HOLD - 1, 0, 0, "R6"); chk("R6", cd_n, 1'b0);
        ticks(1, 1, 0, "R6");
        ticks(HOLD - 1, 0, 0, "R6"); chk("R6", cd_n, 1'b0);
        ticks(1, 0, 0, "R6");        chk("R6", cd_n, 1'b1);
        // R7 fresh reacquire
        ticks(ACQ - 1, 1, 0, "R7"); chk("R7", cd_n, 1'b1);
        ticks(1, 1, 0, "R7");       chk("R7", cd_n, 1'b0);
        // R9 byte mode gate
        ticks(2, 1, 1, "R9"); chk("R9", gate, 1'b1); chk("R8", strm, 1'b1);
        ticks(HOLD, 0, 0, "R6"); chk("R6", cd_n, 1'b1);
        // R4 empty tick restarts the run
        ticks(15, 1, 0, "R4"); ticks(1, 0, 0, "R4");
        ticks(ACQ - 1, 1, 0, "R4"); chk("R4", cd_n, 1'b1);
        ticks(1, 1, 0, "R4");       chk("R4", cd_n, 1'b0);
        // R2 disable clears everything
        cyc(0, 1, 1, 0, "R2"); chk("R2", cd_n, 1'b1);
        cyc(1, 0, 0, 0, "R2");
        ticks(ACQ - 1, 1, 0, "R2"); chk("R2", cd_n, 1'b1);
        ticks(1, 1, 0, "R2");       chk("R2", cd_n, 1'b0);
        ticks(HOLD, 0, 0, "R6");    chk("R6", cd_n, 1'b1);
        // R5 activity only on the tick cycle
        for (int i = 0; i < ACQ; i++) begin
            cyc(1, 0, 0, 0, "R5"); cyc(1, 1, 1, 0, "R5");
        end
        chk("R5", cd_n, 1'b0);
        // random phase
        for (int s = 0; s < 60; s++) begin
            int pct;
            pct = (s % 3 == 0) ? 5 : ((s % 3 == 1) ? 30 : 90);
            for (int i = 0; i < 120; i++)
                cyc(($urandom % 100) < 98, ($urandom % 100) < pct,
                    ($urandom % 4) == 0, 1'($urandom), "R3");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule